// File: doc/BRIEF.md
# Shared Bus Arbiter with Atomic Test-and-Set

This block shares one memory bus among several requesting CPU ports and serves them from a small internal word store. Each port presents a request, a word address, a write flag, write data and a lock flag. The arbiter serves one port at a time. A plain read or plain write holds the bus for a single access cycle.

A request with the lock flag set is a test-and-set. It holds the bus for two access cycles. The first cycle reads the word and the second writes the value 1 into it. A bus lock line stays high across both cycles, and the grant cannot move to another port while it is high. Two ports racing for the same free lock word therefore can never both read 0.

When the bus is free and several ports request, the grant rotates round-robin. A port that loses keeps its request up and is served in a later turn. Each completed request ends with a one-cycle done pulse on the owner's bit. The shared read-data output is valid in that same cycle.

Top module: `bus_lock_arbiter`

## Requirements
- R1: After reset no grant, done or lock bit is high, and every word of the store reads as zero.
- R2: At most one grant bit is high in any cycle. A grant goes only to a port whose request was high in the idle cycle in which arbitration took place. The grant stays on that port from the first access cycle through the done cycle.
- R3: When several ports request in the same idle cycle, the search starts at the port after the one granted last and wraps past the highest port. After reset the search starts at port 0.
- R4: A plain read (lock flag 0, write flag 0) is arbitrated in an idle cycle. Its grant shows in the next cycle, which is the access cycle. Done pulses for one cycle on the owner's bit alone in the cycle after that, and the read-data output then carries the addressed word.
- R5: A plain write (lock flag 0, write flag 1) stores the write data into the addressed word in its access cycle. Its done cycle follows at the same timing as a read and reports the word as it was before the write.
- R6: A test-and-set (lock flag 1; the write flag and write data are ignored) reads the word in its first access cycle and writes 1 in the second. Done comes in the following cycle and carries the old word.
- R7: The bus lock line is high for exactly the two access cycles of a test-and-set and never during a plain access. While it is high, the grant does not change.
- R8: When two ports issue a test-and-set to the same word holding 0 in the same cycle, exactly one of them receives 0 and the other receives 1.
- R9: A requester that is not granted waits with its request held and is served in a later turn. Every request receives exactly one done. A requester holds its address, flags and data until its done and drops its request after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_PORTS | Request per port |
| lock_i | input | N_PORTS | Lock flag per port: 1 selects test-and-set |
| we_i | input | N_PORTS | Write flag per port for plain accesses |
| addr_i | input | N_PORTS*AW | Word address per port, port p at bits p*AW upward |
| wdata_i | input | N_PORTS*DW | Write data per port, port p at bits p*DW upward |
| gnt_o | output | N_PORTS | One-hot grant to the current bus owner |
| done_o | output | N_PORTS | One-cycle completion pulse on the owner's bit |
| rdata_o | output | DW | Word returned with done |
| bus_lock_o | output | 1 | Bus lock line, high during both halves of a test-and-set |

## Verification
Arbitration and an atomic sequence can collide. While one port's test-and-set holds the lock, other ports raise requests on the same word. The bench provokes this by starting two test-and-set requests to one free lock word in the same cycle, and again by starting all four ports at once with mixed operations. A scoreboard predicts the service order from the rotation rule and the returned words from a shadow copy of the store. It judges the race by checking that one port sees 0 and the other sees 1, and that the lock line was counted high for exactly two cycles of each locked operation.

// File: rtl/bus_lock_pkg.sv
package bus_lock_pkg;

    // Bus phases: arbitration, first access, second (locked) access, completion
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2,
        PH_FINISH = 2'd3
    } phase_e;

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] ptr_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);

    // First requester at or after ptr_i, wrapping past the top port
    always_comb begin
        int cand;
        hit_o = 1'b0;
        idx_o = '0;
        for (int k = 0; k < N; k++) begin
            cand = int'(ptr_i) + k;
            if (cand >= N) begin
                cand = cand - N;
            end
            if (!hit_o && req_i[cand]) begin
                hit_o = 1'b1;
                idx_o = IW'(cand);
            end
        end
    end

endmodule

// File: rtl/word_store.sv
module word_store #(
    parameter int AW = 4,
    parameter int DW = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i) begin
            mem_d[addr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/bus_lock_arbiter.sv
module bus_lock_arbiter
    import bus_lock_pkg::*;
#(
    parameter int N_PORTS   = 4,
    parameter int AW        = 4,
    parameter int DW        = 16,
    parameter int SET_VALUE = 1,
    localparam int IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_PORTS-1:0]    req_i,
    input  logic [N_PORTS-1:0]    lock_i,
    input  logic [N_PORTS-1:0]    we_i,
    input  logic [N_PORTS*AW-1:0] addr_i,
    input  logic [N_PORTS*DW-1:0] wdata_i,
    output logic [N_PORTS-1:0]    gnt_o,
    output logic [N_PORTS-1:0]    done_o,
    output logic [DW-1:0]         rdata_o,
    output logic                  bus_lock_o
);

    typedef struct packed {
        phase_e        phase;
        logic [IW-1:0] owner;
        logic [IW-1:0] ptr;
        logic          tas;
        logic [DW-1:0] rdata;
    } arb_state_t;

    localparam arb_state_t ST_RESET = '{PH_IDLE, '0, '0, 1'b0, '0};

    arb_state_t s_d, s_q;

    logic          pick_hit;
    logic [IW-1:0] pick_idx;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] own_addr;
    logic [DW-1:0] own_wdata;
    logic [N_PORTS-1:0] own_hot;

    assign own_addr  = addr_i[int'(s_q.owner)*AW +: AW];
    assign own_wdata = wdata_i[int'(s_q.owner)*DW +: DW];
    assign own_hot   = N_PORTS'(1) << s_q.owner;

    rr_pick #(.N(N_PORTS)) u_pick (
        .req_i (req_i),
        .ptr_i (s_q.ptr),
        .hit_o (pick_hit),
        .idx_o (pick_idx)
    );

    word_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (mem_we),
        .addr_i  (own_addr),
        .wdata_i (mem_wdata),
        .rdata_o (mem_rdata)
    );

    always_comb begin
        s_d       = s_q;
        mem_we    = 1'b0;
        mem_wdata = own_wdata;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (pick_hit) begin
                    s_d.phase = PH_FIRST;
                    s_d.owner = pick_idx;
                    s_d.tas   = lock_i[pick_idx];
                    s_d.ptr   = (pick_idx == IW'(N_PORTS - 1)) ? '0 : pick_idx + 1'b1;
                end
            end
            PH_FIRST: begin
                s_d.rdata = mem_rdata;
                if (s_q.tas) begin
                    s_d.phase = PH_SECOND;
                end else begin
                    mem_we    = we_i[s_q.owner];
                    s_d.phase = PH_FINISH;
                end
            end
            PH_SECOND: begin
                mem_we    = 1'b1;
                mem_wdata = DW'(SET_VALUE);
                s_d.phase = PH_FINISH;
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= ST_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign gnt_o      = (s_q.phase != PH_IDLE) ? own_hot : '0;
    assign done_o     = (s_q.phase == PH_FINISH) ? own_hot : '0;
    assign rdata_o    = s_q.rdata;
    assign bus_lock_o = s_q.tas && ((s_q.phase == PH_FIRST) || (s_q.phase == PH_SECOND));

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    assert_grant_from_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|gnt_o) |-> |(gnt_o & $past(req_i)));

    assert_done_follows_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_o) |-> (done_o == $past(gnt_o)));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_o) |=> !(|done_o));

    assert_lock_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_lock_o) |=> bus_lock_o);

    assert_lock_two_cycles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock_o && $past(bus_lock_o)) |=> !bus_lock_o);

    assert_lock_keeps_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock_o |=> ((gnt_o == $past(gnt_o)) && (|gnt_o)));

endmodule

// File: tb/bus_lock_arbiter_bench.sv
`timescale 1ns/1ps
module bus_lock_arbiter_bench;

    localparam int N  = 4;
    localparam int AW = 4;
    localparam int DW = 16;

    typedef struct {
        int            port;
        logic [DW-1:0] data;
        bit            tas;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req = '0;
    logic [N-1:0]    lock = '0;
    logic [N-1:0]    we = '0;
    logic [N*AW-1:0] addr = '0;
    logic [N*DW-1:0] wdata = '0;
    logic [N-1:0]    gnt;
    logic [N-1:0]    done;
    logic [DW-1:0]   rdata;
    logic            bus_lock;

    int total = 0;
    int fail = 0;
    int rr_ptr = 0;
    int lock_cnt = 0;
    exp_t sb[$];
    logic [DW-1:0] model [16];
    logic [DW-1:0] got [N];
    int            op_k [N];
    logic [AW-1:0] op_a [N];
    logic [DW-1:0] op_d [N];

    always #2 clk = ~clk;

    bus_lock_arbiter #(.N_PORTS(N), .AW(AW), .DW(DW)) u_bus_lock_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .lock_i     (lock),
        .we_i       (we),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .gnt_o      (gnt),
        .done_o     (done),
        .rdata_o    (rdata),
        .bus_lock_o (bus_lock)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // kind: 0 read, 1 write, 2 test-and-set
    task automatic set_op(input int p, input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d);
        op_k[p] = kind;
        op_a[p] = a;
        op_d[p] = d;
        lock[p] = (kind == 2);
        we[p]   = (kind == 1);
        addr[p*AW +: AW]  = a;
        wdata[p*DW +: DW] = d;
    endtask

    // Driver: predicts service order and returned words, then raises requests
    task automatic run(input logic [N-1:0] mask);
        int last;
        last = rr_ptr;
        @(negedge clk);
        for (int k = 0; k < N; k++) begin
            int p;
            p = (rr_ptr + k) % N;
            if (mask[p]) begin
                exp_t e;
                e.port = p;
                e.data = model[op_a[p]];
                e.tas  = (op_k[p] == 2);
                sb.push_back(e);
                if (op_k[p] == 1) model[op_a[p]] = op_d[p];
                else if (op_k[p] == 2) model[op_a[p]] = 16'd1;
                last = p;
            end
        end
        rr_ptr = (last + 1) % N;
        req = req | mask;
        while (req != 0) @(negedge clk);
    endtask

    // Monitor: pops expected items as done pulses appear
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                check($onehot0(gnt), "R2 grant one-hot", 32'(gnt), 32'(0));
                check((gnt & ~req) == 0, "R2 grant only to requester", 32'(gnt), 32'(req));
                if (bus_lock) lock_cnt++;
                if (done != 0) begin
                    int dp;
                    dp = 0;
                    for (int k = 0; k < N; k++) if (done[k]) dp = k;
                    check($onehot(done), "R4 done one-hot", 32'(done), 32'(1 << dp));
                    if (sb.size() == 0) begin
                        check(1'b0, "R9 unexpected done", 32'(dp), 32'hffff_ffff);
                    end else begin
                        e = sb.pop_front();
                        check(dp == e.port, "R3 R9 service order", 32'(dp), 32'(e.port));
                        check(rdata == e.data, "R4 R5 R6 returned word", 32'(rdata), 32'(e.data));
                        check(lock_cnt == (e.tas ? 2 : 0), "R7 lock cycles", 32'(lock_cnt), 32'(e.tas ? 2 : 0));
                    end
                    got[dp] = rdata;
                    lock_cnt = 0;
                    req[dp] = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        fail++;
        $display("FAIL R9 watchdog expired actual=hang expected=completion");
        $display("%0d/%0d checks passed", total - fail, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        for (int i = 0; i < N; i++) got[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(gnt == 0, "R1 reset grant", 32'(gnt), 0);
        check(done == 0, "R1 reset done", 32'(done), 0);
        check(bus_lock == 1'b0, "R1 reset lock", 32'(bus_lock), 0);
        rst_n = 1'b1;

        // R1 R4: store reads zero after reset
        set_op(0, 0, 4'd3, 16'h0); run(4'b0001);
        // R5 write then R4 read back
        set_op(1, 1, 4'd3, 16'hABCD); run(4'b0010);
        set_op(2, 0, 4'd3, 16'h0); run(4'b0100);
        // R6 test-and-set on a free word, then on a taken word
        set_op(0, 2, 4'd5, 16'h0); run(4'b0001);
        set_op(3, 2, 4'd5, 16'h0); run(4'b1000);
        set_op(1, 0, 4'd5, 16'h0); run(4'b0010);
        // R8 race: two test-and-set on one free word; port 2 also sets its write flag (R6 ignores it)
        set_op(1, 2, 4'd7, 16'h0);
        set_op(2, 2, 4'd7, 16'hBEEF);
        we[2] = 1'b1;
        run(4'b0110);
        check((got[1] == 0) != (got[2] == 0), "R8 exactly one winner",
              {got[1], got[2]}, 32'h0000_0001);
        check((got[1] | got[2]) == 16'd1, "R8 loser sees one", 32'(got[1] | got[2]), 32'd1);
        // R9 all ports at once with mixed operations
        set_op(3, 1, 4'd9, 16'h0055); run(4'b1000);
        set_op(0, 2, 4'd9, 16'h0);
        set_op(1, 0, 4'd9, 16'h0);
        set_op(2, 1, 4'd9, 16'h1234);
        set_op(3, 0, 4'd9, 16'h0);
        run(4'b1111);
        // R3 wrap of the rotation
        set_op(2, 0, 4'd0, 16'h0); run(4'b0100);
        set_op(3, 0, 4'd1, 16'h0);
        set_op(0, 0, 4'd2, 16'h0);
        set_op(1, 1, 4'd0, 16'h7777);
        run(4'b1011);
        set_op(0, 0, 4'd0, 16'h0); run(4'b0001);

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R9 every request served", 32'(sb.size()), 0);
        $display("%0d/%0d checks passed", total - fail, total);
        $finish;
    end

endmodule